// File: doc/BRIEF.md
# Descriptor Table Walker for an Audio Bus Master

This block steps through a list of region descriptors in memory on behalf of an audio bus master. Software supplies the byte address of the list and raises an enable level. On that rising edge the walker reads the first entry through a 32-bit read port that takes a request and later returns a response. Each entry is two words: the start address of a memory region, then a control word. The control word holds a 16-bit byte count in its low half and flag bits in its high half.

While a region is active the walker shows its current address and the bytes still left to the data mover. The mover reports how many bytes it took, and the walker moves the address forward and lowers the count. When the count reaches zero the walker signals completion. It then fetches the next entry from memory, or it halts if the entry was flagged as the last one. Entries are never held between uses: every entry is read from memory at the moment it is needed.

Top module: `dma_desc_walker`

## Requirements
- R1: After reset, mem_req, region_valid, region_done, region_irq and table_end are 0, and cur_remain is 0.
- R2: A rising edge of en starts a walk. The first read goes to tbl_base with its two low bits forced to zero, and the second read goes to that address plus 4.
- R3: The first word of an entry becomes cur_addr. Bits 15:0 of the second word become cur_remain. region_valid is 1 from the edge that accepts the second response.
- R4: A byte count of 0 in bits 15:0 loads cur_remain as 65536.
- R5: A take of n bytes moves cur_addr up by min(n, cur_remain) and lowers cur_remain by that same amount.
- R6: When cur_remain reaches zero, region_done is a one-cycle pulse on the edge that takes the last bytes. region_irq pulses in the same cycle only if bit 30 of the control word was 1.
- R7: When an entry without the last-entry flag (bit 31 of the control word) completes, the next entry is read from memory at the following 8-byte position.
- R8: When an entry with bit 31 set completes, table_end is set and held, and no further read is issued until en falls and rises again. A new start clears table_end.
- R9: While en is low the walk is aborted: region_valid and mem_req are 0 from the next edge. The next rising edge of en restarts the walk at tbl_base.
- R10: Only one read is outstanding at a time, and mem_req never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Walk enable level; a rising edge starts a walk |
| tbl_base | input | 32 | Byte address of the descriptor list |
| mem_req | output | 1 | Read request, one-cycle pulse |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mv_take | input | 1 | Data mover consumed bytes this cycle |
| mv_bytes | input | 17 | Number of bytes consumed |
| cur_addr | output | 32 | Current region address |
| cur_remain | output | 17 | Bytes left in the current region |
| region_valid | output | 1 | A region is loaded and active |
| region_done | output | 1 | Region completion pulse |
| region_irq | output | 1 | Completion pulse for regions flagged for interrupt |
| table_end | output | 1 | Sticky: the last entry has completed |

## Verification
Each read request is visible in the cycle after the edge that enters a fetch state. The bench's memory model answers on the falling edge after the request, so that response is accepted at the next rising edge. cur_addr, cur_remain and region_valid change at the edge that accepts the second response. region_done, region_irq, table_end and the new address and count all appear right after the edge that samples mv_take. The bench drives mv_take for exactly one edge and reads every result at the falling edge that follows. It records every request address, so fetch order and fetch addresses are checked without depending on a fixed memory latency.

// File: rtl/dma_desc_walker_pkg.sv
package dma_desc_walker_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_REQ0  = 3'd1,
      S_WAIT0 = 3'd2,
      S_REQ1  = 3'd3,
      S_WAIT1 = 3'd4,
      S_RUN   = 3'd5
   } walk_state_e;
endpackage

// File: rtl/dma_desc_region.sv
module dma_desc_region #(
   parameter int AW    = 32,
   parameter int LEN_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            ld,
   input  logic [AW-1:0]   ld_addr,
   input  logic [LEN_W:0]  ld_len,
   input  logic            take,
   input  logic [LEN_W:0]  take_bytes,
   output logic [AW-1:0]   addr,
   output logic [LEN_W:0]  remain,
   output logic            active,
   output logic            last
);
   logic [AW-1:0]  addr_q;
   logic [LEN_W:0] rem_q;
   logic           act_q;
   logic           covers;
   logic [LEN_W:0] step;

   assign covers = (take_bytes >= rem_q);
   assign step   = covers ? rem_q : take_bytes;
   assign last   = act_q & take & covers;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
         act_q  <= 1'b0;
      end else if (clr) begin
         act_q  <= 1'b0;
      end else if (ld) begin
         addr_q <= ld_addr;
         rem_q  <= ld_len;
         act_q  <= 1'b1;
      end else if (act_q && take) begin
         addr_q <= addr_q + AW'(step);
         rem_q  <= rem_q - step;
         if (covers) act_q <= 1'b0;
      end
   end

   assign addr   = addr_q;
   assign remain = rem_q;
   assign active = act_q;
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
   import dma_desc_walker_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LEN_W       = 16,
   parameter int EOT_BIT     = 31,
   parameter int IRQ_BIT     = 30,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [AW-1:0]   tbl_base,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_rvalid,
   input  logic [AW-1:0]   mem_rdata,
   output logic            ld,
   output logic [AW-1:0]   ld_addr,
   output logic [LEN_W:0]  ld_len,
   input  logic            region_last,
   output logic            region_done,
   output logic            region_irq,
   output logic            table_end
);
   localparam int WORD_B = 4;

   walk_state_e    state_q;
   logic [AW-1:0]  ptr_q;
   logic [AW-1:0]  word0_q;
   logic           en_q;
   logic           eot_q;
   logic           irqf_q;
   logic           done_q;
   logic           irqp_q;
   logic           end_q;
   logic [LEN_W-1:0] cnt;

   assign cnt = mem_rdata[LEN_W-1:0];

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         assign ld_len = (cnt == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, cnt};
      end else begin : g_zero_plain
         assign ld_len = {1'b0, cnt};
      end
   endgenerate

   assign ld       = en && (state_q == S_WAIT1) && mem_rvalid;
   assign ld_addr  = word0_q;
   assign mem_req  = (state_q == S_REQ0) || (state_q == S_REQ1);
   assign mem_addr = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         ptr_q   <= '0;
         word0_q <= '0;
         en_q    <= 1'b0;
         eot_q   <= 1'b0;
         irqf_q  <= 1'b0;
         done_q  <= 1'b0;
         irqp_q  <= 1'b0;
         end_q   <= 1'b0;
      end else begin
         en_q   <= en;
         done_q <= 1'b0;
         irqp_q <= 1'b0;
         if (!en) begin
            state_q <= S_IDLE;
         end else begin
            case (state_q)
               S_IDLE: if (!en_q) begin
                  state_q <= S_REQ0;
                  ptr_q   <= {tbl_base[AW-1:2], 2'b00};
                  end_q   <= 1'b0;
               end
               S_REQ0:  state_q <= S_WAIT0;
               S_WAIT0: if (mem_rvalid) begin
                  word0_q <= mem_rdata;
                  ptr_q   <= ptr_q + AW'(WORD_B);
                  state_q <= S_REQ1;
               end
               S_REQ1:  state_q <= S_WAIT1;
               S_WAIT1: if (mem_rvalid) begin
                  eot_q   <= mem_rdata[EOT_BIT];
                  irqf_q  <= mem_rdata[IRQ_BIT];
                  ptr_q   <= ptr_q + AW'(WORD_B);
                  state_q <= S_RUN;
               end
               S_RUN: if (region_last) begin
                  done_q <= 1'b1;
                  irqp_q <= irqf_q;
                  if (eot_q) begin
                     state_q <= S_IDLE;
                     end_q   <= 1'b1;
                  end else begin
                     state_q <= S_REQ0;
                  end
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

   assign region_done = done_q;
   assign region_irq  = irqp_q;
   assign table_end   = end_q;
endmodule

// File: rtl/dma_desc_walker.sv
module dma_desc_walker #(
   parameter int AW          = 32,
   parameter int LEN_W       = 16,
   parameter int EOT_BIT     = 31,
   parameter int IRQ_BIT     = 30,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [AW-1:0]    tbl_base,
   output logic             mem_req,
   output logic [AW-1:0]    mem_addr,
   input  logic             mem_rvalid,
   input  logic [AW-1:0]    mem_rdata,
   input  logic             mv_take,
   input  logic [LEN_W:0]   mv_bytes,
   output logic [AW-1:0]    cur_addr,
   output logic [LEN_W:0]   cur_remain,
   output logic             region_valid,
   output logic             region_done,
   output logic             region_irq,
   output logic             table_end
);
   generate
      if (AW < 8)                         begin : g_bad_aw   $error("AW too small");            end
      if (LEN_W < 1 || LEN_W >= AW)       begin : g_bad_len  $error("LEN_W out of range");      end
      if (EOT_BIT >= AW || IRQ_BIT >= AW) begin : g_bad_flag $error("flag bit beyond word");    end
      if (EOT_BIT == IRQ_BIT)             begin : g_same     $error("flag bits must differ");   end
      if (EOT_BIT < LEN_W || IRQ_BIT < LEN_W) begin : g_ovl  $error("flag overlaps byte count"); end
   endgenerate

   logic           ld;
   logic [AW-1:0]  ld_addr;
   logic [LEN_W:0] ld_len;
   logic           last;

   dma_desc_seq #(
      .AW(AW), .LEN_W(LEN_W), .EOT_BIT(EOT_BIT),
      .IRQ_BIT(IRQ_BIT), .ZERO_IS_MAX(ZERO_IS_MAX)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .tbl_base(tbl_base),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .ld(ld), .ld_addr(ld_addr), .ld_len(ld_len),
      .region_last(last), .region_done(region_done),
      .region_irq(region_irq), .table_end(table_end)
   );

   dma_desc_region #(.AW(AW), .LEN_W(LEN_W)) u_region (
      .clk(clk), .rst_n(rst_n), .clr(~en), .ld(ld),
      .ld_addr(ld_addr), .ld_len(ld_len),
      .take(mv_take), .take_bytes(mv_bytes),
      .addr(cur_addr), .remain(cur_remain),
      .active(region_valid), .last(last)
   );
endmodule

// File: rtl/dma_desc_walker_chk.sv
module dma_desc_walker_chk #(
   parameter int AW    = 32,
   parameter int LEN_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            mv_take,
   input logic            mem_req,
   input logic [AW-1:0]   mem_addr,
   input logic            region_valid,
   input logic            region_done,
   input logic            region_irq,
   input logic            table_end,
   input logic [LEN_W:0]  cur_remain
);
   p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   p_remain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && region_valid && !mv_take) |=> $stable(cur_remain));

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      region_done |=> !region_done);

   p_irq_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      region_irq |-> region_done);

   p_end_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      table_end |-> !mem_req);

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!region_valid && !mem_req));

   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
endmodule

bind dma_desc_walker dma_desc_walker_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .mv_take(mv_take),
   .mem_req(mem_req), .mem_addr(mem_addr),
   .region_valid(region_valid), .region_done(region_done),
   .region_irq(region_irq), .table_end(table_end),
   .cur_remain(cur_remain)
);

// File: tb/dma_desc_walker_bench.sv
module dma_desc_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [31:0] tbl_base = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mv_take = 1'b0;
   logic [16:0] mv_bytes = '0;
   logic [31:0] cur_addr;
   logic [16:0] cur_remain;
   logic        region_valid, region_done, region_irq, table_end;

   int checks = 0;
   int fails  = 0;
   logic [31:0] mem [0:63];
   logic [31:0] req_log [0:31];
   int nreq = 0;
   bit pend = 1'b0;
   logic [5:0] pend_idx = '0;
   int overlap = 0;
   bit done_run = 1'b0;

   localparam logic [31:0] F_EOT = 32'h8000_0000;
   localparam logic [31:0] F_IRQ = 32'h4000_0000;

   always #2 clk = ~clk;

   dma_desc_walker u_dma_desc_walker (
      .clk(clk), .rst_n(rst_n), .en(en), .tbl_base(tbl_base),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .mv_take(mv_take), .mv_bytes(mv_bytes),
      .cur_addr(cur_addr), .cur_remain(cur_remain),
      .region_valid(region_valid), .region_done(region_done),
      .region_irq(region_irq), .table_end(table_end)
   );

   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[pend_idx];
            pend = 1'b0;
         end
         if (mem_req) begin
            if (pend || mem_rvalid) overlap++;
            pend = 1'b1;
            pend_idx = mem_addr[7:2];
            if (nreq < 32) req_log[nreq] = mem_addr;
            nreq++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 40; i++) begin
         if (region_valid) break;
         @(negedge clk);
      end
   endtask

   task automatic take(input int n);
      mv_take = 1'b1;
      mv_bytes = 17'(n);
      @(negedge clk);
      mv_take = 1'b0;
   endtask

   task automatic start(input logic [31:0] base);
      en = 1'b0;
      repeat (3) @(negedge clk);
      tbl_base = base;
      nreq = 0;
      en = 1'b1;
      @(negedge clk);
      wait_valid();
   endtask

   task automatic t_reset();
      chk(!mem_req && !region_valid && !region_done && !region_irq && !table_end,
          "R1", "control outputs", {27'd0, mem_req, region_valid, region_done, region_irq, table_end}, 32'd0);
      chk(cur_remain == 17'd0, "R1", "cur_remain", 32'(cur_remain), 32'd0);
   endtask

   task automatic t_walk();
      start(32'h0000_0000);
      chk(nreq == 2 && req_log[0] == 32'h0, "R2", "first read addr", req_log[0], 32'h0);
      chk(req_log[1] == 32'h4, "R2", "second read addr", req_log[1], 32'h4);
      chk(region_valid && cur_addr == 32'h1000_0000, "R3", "cur_addr", cur_addr, 32'h1000_0000);
      chk(cur_remain == 17'd16, "R3", "cur_remain", 32'(cur_remain), 32'd16);
      take(6);
      chk(cur_addr == 32'h1000_0006, "R5", "addr after take", cur_addr, 32'h1000_0006);
      chk(cur_remain == 17'd10 && !region_done, "R5", "remain after take", 32'(cur_remain), 32'd10);
      take(20);
      chk(region_done && cur_remain == 17'd0, "R6", "done on clamp", {15'd0, cur_remain}, 32'd0);
      chk(region_irq, "R6", "irq flagged region", 32'(region_irq), 32'd1);
      chk(cur_addr == 32'h1000_0010, "R5", "addr clamped", cur_addr, 32'h1000_0010);
      @(negedge clk);
      chk(!region_done, "R6", "done one cycle", 32'(region_done), 32'd0);
      wait_valid();
      chk(nreq == 4 && req_log[2] == 32'h8, "R7", "next entry word0 addr", req_log[2], 32'h8);
      chk(req_log[3] == 32'hC, "R7", "next entry word1 addr", req_log[3], 32'hC);
      chk(cur_addr == 32'h2000_0040 && cur_remain == 17'd8, "R7", "next region addr", cur_addr, 32'h2000_0040);
      take(8);
      chk(region_done && !region_irq, "R6", "done without irq", 32'(region_irq), 32'd0);
      chk(table_end, "R8", "table_end set", 32'(table_end), 32'd1);
      repeat (10) @(negedge clk);
      chk(nreq == 4 && table_end && !region_valid, "R8", "no fetch after end", 32'(nreq), 32'd4);
   endtask

   task automatic t_zero();
      start(32'h0000_0040);
      chk(!table_end, "R8", "restart clears table_end", 32'(table_end), 32'd0);
      chk(req_log[0] == 32'h40, "R9", "restart at new base", req_log[0], 32'h40);
      chk(cur_remain == 17'h10000, "R4", "zero count is 65536", 32'(cur_remain), 32'h10000);
      take(65535);
      chk(cur_remain == 17'd1 && !region_done, "R4", "remain 1", 32'(cur_remain), 32'd1);
      take(1);
      chk(region_done && cur_addr == 32'h3001_0000, "R4", "end addr", cur_addr, 32'h3001_0000);
   endtask

   task automatic t_align_abort();
      start(32'h0000_0083);
      chk(req_log[0] == 32'h80 && req_log[1] == 32'h84, "R2", "low bits ignored", req_log[0], 32'h80);
      chk(cur_addr == 32'h4000_0100 && cur_remain == 17'd12, "R3", "aligned entry", 32'(cur_remain), 32'd12);
      take(4);
      en = 1'b0;
      @(negedge clk);
      chk(!region_valid, "R9", "abort drops region", 32'(region_valid), 32'd0);
      nreq = 0;
      repeat (5) @(negedge clk);
      chk(nreq == 0, "R9", "no reads while off", 32'(nreq), 32'd0);
      en = 1'b1;
      @(negedge clk);
      wait_valid();
      chk(req_log[0] == 32'h80 && cur_remain == 17'd12, "R9", "restart from base", req_log[0], 32'h80);
      chk(overlap == 0, "R10", "single outstanding read", 32'(overlap), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      mem[0]  = 32'h1000_0000; mem[1]  = F_IRQ | 32'h0010;
      mem[2]  = 32'h2000_0040; mem[3]  = F_EOT | 32'h0008;
      mem[16] = 32'h3000_0000; mem[17] = F_EOT | 32'h0000;
      mem[32] = 32'h4000_0100; mem[33] = F_EOT | 32'h000C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_walk();
      t_zero();
      t_align_abort();
      if (!done_run) begin
         done_run = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_run) begin
         done_run = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule